// File: doc/BRIEF.md
# Serial Adapter I/O Window Glue

This block is the bus-side glue for a one-port serial card that sits on a PC-style 10-bit I/O bus. It watches the address bus and claims an 8-byte window whose base is set by seven switch inputs. The lower half of the window is passed on to a two-channel serial controller as a chip select plus a 2-bit register index. The upper half holds a small board port, which drives the modem DTR line and a software DMA enable, and reads back an active-low summary of the line, interrupt and DMA state.

The block also keeps a DMA terminal-count flag. The flag is set when the DMA engine signals terminal count while acknowledging the chosen channel, and it is cleared by any write to a dedicated clear location in the window. The card interrupt line merges this flag with the serial controller's own interrupt. A 2-bit strap picks what enables the DMA request/acknowledge drivers.

All logic runs on one clock with a synchronous active-high reset. Bus strobes are sampled as one-cycle pulses. Every output is registered.

Top module: `isa_serial_glue`

## Requirements
- R1: A read or write strobe whose address falls at window offsets 0..3 raises `scc_cs` for exactly the following cycle, with `scc_reg` equal to the offset (bit 1 selects channel B, bit 0 selects the control register rather than data).
- R2: The window base is A9..A3 = bitwise NOT of `sw_base_on` (a closed switch gives address bit 0), with A2..A0 giving the offset. Accesses outside the window, accesses while `io_aen` is high, and accesses while `sw_port_on` is low are ignored: no chip select, no register change, and reads return 0xFF.
- R3: A switch setting that places the base below 0x100 decodes nothing, so the usable bases are 0x100 to 0x3F8 in steps of 8.
- R4: A write to offset 4 loads `dtr` from data bit 0 (1 = asserted) and the software DMA enable from data bit 7 (1 = enabled). Bits 1..6 have no effect.
- R5: A read of offset 4 returns on `rd_data` in the next cycle: bit 0 = NOT DSR-on, bit 3 = NOT controller-interrupt, bit 5 = NOT terminal-count flag, bit 7 = NOT `dma_drv_en`, and all other bits 1. Reads of offsets 5..7 and all idle cycles return 0xFF.
- R6: After reset `dtr`, `scc_cs`, `irq`, `dma_drv_en`, the software DMA enable and the terminal-count flag are 0, and `rd_data` is 0xFF.
- R7: When `tc_irq_mode` is 1, a cycle with `dma_tc` high and `dma_ack[dma_ch_sel]` high sets the terminal-count flag. TC with another channel's acknowledge, or with the mode off, leaves the flag unchanged. Once set, the flag holds until it is cleared.
- R8: Any write to offset 5 clears the flag whatever its data. A set and a clear in the same cycle leave the flag set.
- R9: `dma_src` picks the driver enable, one cycle after its inputs: 0 = always on, 1 = software DMA enable bit, 2 = `scc_rtsb`, 3 = always off.
- R10: `irq` equals `irq_enable` AND (`scc_irq` OR flag), delayed by one register. Writes to the window never clear a pending controller interrupt.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| io_addr | input | 10 | I/O address A9..A0 |
| io_rd | input | 1 | Read strobe, one cycle |
| io_wr | input | 1 | Write strobe, one cycle |
| io_wdata | input | 8 | Write data |
| io_aen | input | 1 | Address enable; high means a DMA cycle, so decoding is suppressed |
| sw_base_on | input | 7 | Base switches for A9..A3, 1 = closed |
| sw_port_on | input | 1 | Port enable switch, 1 = closed (enabled) |
| dma_src | input | 2 | Driver enable source select |
| tc_irq_mode | input | 1 | Terminal-count interrupt mode enable |
| irq_enable | input | 1 | Interrupt output enable |
| dma_ch_sel | input | 2 | DMA channel watched for terminal count |
| dma_ack | input | 4 | Per-channel DMA acknowledge, active high |
| dma_tc | input | 1 | DMA terminal count |
| scc_rtsb | input | 1 | Controller channel B RTS |
| scc_irq | input | 1 | Controller interrupt pending |
| modem_dsr_on | input | 1 | DSR asserted |
| rd_data | output | 8 | Board port read data |
| scc_cs | output | 1 | Controller chip select |
| scc_reg | output | 2 | Controller register index |
| dtr | output | 1 | DTR drive |
| dma_drv_en | output | 1 | DMA request/acknowledge driver enable |
| irq | output | 1 | Card interrupt |

## Verification
The flag has two entries that can fall in the same edge: a terminal-count set and a clear write to offset 5. The bench raises `dma_tc` with the selected acknowledge in the same cycle as the clear strobe. It then reads the status port, and expects bit 5 to be 0, meaning the set won. A second pair to watch is the controller interrupt and a clear write. The bench holds `scc_irq` high, issues writes to offsets 4 and 5, and confirms that `irq` and status bit 3 still report the pending interrupt. The decode is swept over all 128 switch settings and the addresses just around each window.

// File: rtl/glue_pkg.sv
package glue_pkg;
  typedef enum logic [1:0] {
    DRV_ALWAYS = 2'd0,
    DRV_SWBIT  = 2'd1,
    DRV_RTSB   = 2'd2,
    DRV_NEVER  = 2'd3
  } drv_src_e;

  localparam logic [2:0] OFS_BOARD = 3'd4;
  localparam logic [2:0] OFS_TCCLR = 3'd5;

  localparam int ST_DSR_BIT = 0;
  localparam int ST_SCC_BIT = 3;
  localparam int ST_TC_BIT  = 5;
endpackage

// File: rtl/io_window_decode.sv
module io_window_decode #(
  parameter int ADDR_W   = 10,
  parameter int WIN_BITS = 3,
  parameter int MIN_BASE = 'h100,
  localparam int SW_W    = ADDR_W - WIN_BITS
) (
  input  logic [ADDR_W-1:0]   addr,
  input  logic [SW_W-1:0]     sw_on,
  input  logic                port_en,
  input  logic                aen,
  output logic                hit,
  output logic [WIN_BITS-1:0] offset
);
  logic [SW_W-1:0]   base_hi;
  logic [ADDR_W-1:0] base_full;
  logic              legal;

  always_comb begin
    base_hi   = ~sw_on;
    base_full = {base_hi, {WIN_BITS{1'b0}}};
    legal     = (base_full >= ADDR_W'(MIN_BASE));
    hit       = port_en && !aen && legal && (addr[ADDR_W-1:WIN_BITS] == base_hi);
    offset    = addr[WIN_BITS-1:0];
  end
endmodule

// File: rtl/board_ctrl_port.sv
module board_ctrl_port
  import glue_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_ctrl,
  input  logic              wr_dtr_bit,
  input  logic              wr_en_bit,
  input  logic              rd_ctrl,
  input  logic              dsr_on,
  input  logic              scc_irq,
  input  logic              tc_flag,
  input  logic              drv_en,
  output logic              dtr,
  output logic              sw_dma_en,
  output logic [DATA_W-1:0] rd_data
);
  logic [DATA_W-1:0] status;

  always_comb begin
    status             = '1;
    status[ST_DSR_BIT] = ~dsr_on;
    status[ST_SCC_BIT] = ~scc_irq;
    status[ST_TC_BIT]  = ~tc_flag;
    status[DATA_W-1]   = ~drv_en;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      dtr       <= 1'b0;
      sw_dma_en <= 1'b0;
      rd_data   <= '1;
    end else begin
      if (wr_ctrl) begin
        dtr       <= wr_dtr_bit;
        sw_dma_en <= wr_en_bit;
      end
      rd_data <= rd_ctrl ? status : '1;
    end
  end

  // R4
  dtr_stable_chk: assert property (@(posedge clk) disable iff (rst)
    !wr_ctrl |=> $stable(dtr));
endmodule

// File: rtl/tc_irq_latch.sv
module tc_irq_latch #(
  parameter int DMA_CHANS = 4,
  localparam int SEL_W    = $clog2(DMA_CHANS)
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 mode_en,
  input  logic                 tc,
  input  logic [DMA_CHANS-1:0] dack,
  input  logic [SEL_W-1:0]     ch_sel,
  input  logic                 clr,
  output logic                 flag
);
  logic set_cond;

  always_comb set_cond = mode_en && tc && dack[ch_sel];

  always_ff @(posedge clk) begin
    if (rst)           flag <= 1'b0;
    else if (set_cond) flag <= 1'b1;
    else if (clr)      flag <= 1'b0;
  end

  // R8
  set_over_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (mode_en && tc && dack[ch_sel]) |=> flag);
  // R7
  flag_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (flag && !clr) |=> flag);
endmodule

// File: rtl/isa_serial_glue.sv
module isa_serial_glue
  import glue_pkg::*;
#(
  parameter int ADDR_W    = 10,
  parameter int DATA_W    = 8,
  parameter int WIN_BITS  = 3,
  parameter int MIN_BASE  = 'h100,
  parameter int DMA_CHANS = 4,
  localparam int SW_W     = ADDR_W - WIN_BITS,
  localparam int SEL_W    = $clog2(DMA_CHANS)
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [ADDR_W-1:0]    io_addr,
  input  logic                 io_rd,
  input  logic                 io_wr,
  input  logic [DATA_W-1:0]    io_wdata,
  input  logic                 io_aen,
  input  logic [SW_W-1:0]      sw_base_on,
  input  logic                 sw_port_on,
  input  logic [1:0]           dma_src,
  input  logic                 tc_irq_mode,
  input  logic                 irq_enable,
  input  logic [SEL_W-1:0]     dma_ch_sel,
  input  logic [DMA_CHANS-1:0] dma_ack,
  input  logic                 dma_tc,
  input  logic                 scc_rtsb,
  input  logic                 scc_irq,
  input  logic                 modem_dsr_on,
  output logic [DATA_W-1:0]    rd_data,
  output logic                 scc_cs,
  output logic [1:0]           scc_reg,
  output logic                 dtr,
  output logic                 dma_drv_en,
  output logic                 irq
);
  logic                hit;
  logic [WIN_BITS-1:0] offset;
  logic                scc_sel, board_sel, clr_sel;
  logic                sw_dma_en, tc_flag;
  logic                unused_wbits;
  drv_src_e            src;

  assign unused_wbits = ^io_wdata[DATA_W-2:1];

  io_window_decode #(.ADDR_W(ADDR_W), .WIN_BITS(WIN_BITS), .MIN_BASE(MIN_BASE)) u_dec (
    .addr(io_addr), .sw_on(sw_base_on), .port_en(sw_port_on), .aen(io_aen),
    .hit(hit), .offset(offset)
  );

  always_comb begin
    scc_sel   = hit && !offset[WIN_BITS-1];
    board_sel = hit && (offset == OFS_BOARD);
    clr_sel   = hit && (offset == OFS_TCCLR);
    src       = drv_src_e'(dma_src);
  end

  board_ctrl_port #(.DATA_W(DATA_W)) u_port (
    .clk(clk), .rst(rst),
    .wr_ctrl(board_sel && io_wr),
    .wr_dtr_bit(io_wdata[0]),
    .wr_en_bit(io_wdata[DATA_W-1]),
    .rd_ctrl(board_sel && io_rd),
    .dsr_on(modem_dsr_on), .scc_irq(scc_irq), .tc_flag(tc_flag), .drv_en(dma_drv_en),
    .dtr(dtr), .sw_dma_en(sw_dma_en), .rd_data(rd_data)
  );

  tc_irq_latch #(.DMA_CHANS(DMA_CHANS)) u_tc (
    .clk(clk), .rst(rst), .mode_en(tc_irq_mode), .tc(dma_tc), .dack(dma_ack),
    .ch_sel(dma_ch_sel), .clr(clr_sel && io_wr), .flag(tc_flag)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      scc_cs     <= 1'b0;
      scc_reg    <= 2'b00;
      dma_drv_en <= 1'b0;
      irq        <= 1'b0;
    end else begin
      scc_cs  <= scc_sel && (io_rd || io_wr);
      scc_reg <= offset[1:0];
      case (src)
        DRV_ALWAYS: dma_drv_en <= 1'b1;
        DRV_SWBIT:  dma_drv_en <= sw_dma_en;
        DRV_RTSB:   dma_drv_en <= scc_rtsb;
        default:    dma_drv_en <= 1'b0;
      endcase
      irq <= irq_enable && (scc_irq || tc_flag);
    end
  end

  // R9
  never_mode_chk: assert property (@(posedge clk) disable iff (rst)
    (dma_src == 2'd3) |=> !dma_drv_en);
  // R10
  irq_gate_chk: assert property (@(posedge clk) disable iff (rst)
    !irq_enable |=> !irq);
  // R1
  cs_needs_strobe_chk: assert property (@(posedge clk) disable iff (rst)
    scc_cs |-> $past(io_rd || io_wr));
  // R2
  aen_block_chk: assert property (@(posedge clk) disable iff (rst)
    (io_aen && (io_rd || io_wr)) |=> !scc_cs);
endmodule

// File: tb/isa_serial_glue_test.sv
module isa_serial_glue_test;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [9:0] io_addr = '0;
  logic       io_rd = 1'b0, io_wr = 1'b0;
  logic [7:0] io_wdata = '0;
  logic       io_aen = 1'b0;
  logic [6:0] sw_base_on = '0;
  logic       sw_port_on = 1'b1;
  logic [1:0] dma_src = 2'd3;
  logic       tc_irq_mode = 1'b0, irq_enable = 1'b0;
  logic [1:0] dma_ch_sel = '0;
  logic [3:0] dma_ack = '0;
  logic       dma_tc = 1'b0, scc_rtsb = 1'b0, scc_irq = 1'b0, modem_dsr_on = 1'b0;
  logic [7:0] rd_data;
  logic       scc_cs;
  logic [1:0] scc_reg;
  logic       dtr, dma_drv_en, irq;

  int vectors = 0;
  int miscompares = 0;
  logic [7:0] snap_rd;
  logic       snap_cs;
  logic [1:0] snap_reg;

  always #2 clk = ~clk;

  isa_serial_glue uut (
    .clk(clk), .rst(rst), .io_addr(io_addr), .io_rd(io_rd), .io_wr(io_wr),
    .io_wdata(io_wdata), .io_aen(io_aen), .sw_base_on(sw_base_on), .sw_port_on(sw_port_on),
    .dma_src(dma_src), .tc_irq_mode(tc_irq_mode), .irq_enable(irq_enable),
    .dma_ch_sel(dma_ch_sel), .dma_ack(dma_ack), .dma_tc(dma_tc), .scc_rtsb(scc_rtsb),
    .scc_irq(scc_irq), .modem_dsr_on(modem_dsr_on), .rd_data(rd_data), .scc_cs(scc_cs),
    .scc_reg(scc_reg), .dtr(dtr), .dma_drv_en(dma_drv_en), .irq(irq)
  );

  task automatic check(input string req, input int act, input int exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_write(input logic [9:0] a, input logic [7:0] d);
    @(negedge clk);
    io_addr = a; io_wdata = d; io_wr = 1'b1;
    @(negedge clk);
    io_wr = 1'b0;
  endtask

  task automatic do_read(input logic [9:0] a);
    @(negedge clk);
    io_addr = a; io_rd = 1'b1;
    @(negedge clk);
    io_rd = 1'b0;
    snap_rd = rd_data; snap_cs = scc_cs; snap_reg = scc_reg;
  endtask

  function automatic logic [6:0] sw_for(input int base);
    return ~7'(base >> 3);
  endfunction

  function automatic logic [7:0] status_exp(input bit dsr, input bit si, input bit tcf, input bit drv);
    logic [7:0] s;
    s = 8'hFF;
    s[0] = ~dsr; s[3] = ~si; s[5] = ~tcf; s[7] = ~drv;
    return s;
  endfunction

  localparam int BASE = 'h300;

  initial begin
    repeat (1500000) @(posedge clk);
    miscompares++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    sw_base_on = sw_for(BASE);
    idle(3);
    rst = 1'b0;
    idle(1);
    // R6 reset state
    check("R6 dtr", dtr, 0);
    check("R6 scc_cs", scc_cs, 0);
    check("R6 irq", irq, 0);
    check("R6 dma_drv_en", dma_drv_en, 0);
    check("R6 rd_data", rd_data, 8'hFF);
    dma_src = 2'd1; idle(2);
    check("R6 sw dma enable cleared", dma_drv_en, 0);

    // R1 R2 R3 R5: sweep every switch setting and the addresses around each window
    modem_dsr_on = 1'b1; scc_irq = 1'b1; dma_src = 2'd0;
    idle(2);
    for (int sw = 0; sw < 128; sw++) begin
      int base;
      bit legal;
      sw_base_on = 7'(sw);
      base  = {~7'(sw), 3'b000};
      legal = (base >= 'h100);
      for (int k = -1; k <= 8; k++) begin
        logic [9:0] a;
        bit inwin;
        a = 10'(base + k);
        inwin = legal && (k >= 0) && (k <= 7);
        do_read(a);
        check("R1/R2/R3 chip select", snap_cs, (inwin && k < 4) ? 1 : 0);
        if (inwin && k < 4) check("R1 register index", snap_reg, k & 3);
        check("R5/R2 read data", snap_rd, (inwin && k == 4) ? status_exp(1, 1, 0, 1) : 8'hFF);
      end
    end
    sw_base_on = sw_for(BASE);
    scc_irq = 1'b0;

    // R4 control writes
    do_write(10'(BASE + 4), 8'h01);
    check("R4 dtr set", dtr, 1);
    do_write(10'(BASE + 4), 8'h7E);
    check("R4 bits 1..6 ignored, dtr cleared", dtr, 0);
    dma_src = 2'd1;
    idle(2);
    check("R4 bits 1..6 do not enable dma", dma_drv_en, 0);
    do_write(10'(BASE + 4), 8'h80);
    idle(1);
    check("R4 bit7 enables dma", dma_drv_en, 1);
    check("R4 dtr from bit0", dtr, 0);
    do_read(10'(BASE + 4));
    check("R5 status dma enabled", snap_rd, status_exp(1, 0, 0, 1));

    // R2 ignored accesses
    io_aen = 1'b1;
    do_write(10'(BASE + 4), 8'h01);
    check("R2 aen write ignored", dtr, 0);
    do_read(10'(BASE + 4));
    check("R2 aen read ignored", snap_rd, 8'hFF);
    do_read(10'(BASE + 1));
    check("R2 aen no chip select", snap_cs, 0);
    io_aen = 1'b0;
    sw_port_on = 1'b0;
    do_write(10'(BASE + 4), 8'h01);
    check("R2 port off write ignored", dtr, 0);
    do_read(10'(BASE + 2));
    check("R2 port off no chip select", snap_cs, 0);
    sw_port_on = 1'b1;
    do_write(10'(BASE + 12), 8'h01);
    check("R2 outside window write ignored", dtr, 0);

    // R9 driver enable source sweep
    for (int m = 0; m < 4; m++)
      for (int s = 0; s < 2; s++)
        for (int r = 0; r < 2; r++) begin
          do_write(10'(BASE + 4), {s[0], 7'b0});
          dma_src = 2'(m); scc_rtsb = r[0];
          idle(3);
          check("R9 driver enable", dma_drv_en,
                (m == 0) ? 1 : (m == 1) ? s : (m == 2) ? r : 0);
        end
    dma_src = 2'd3; scc_rtsb = 1'b0;
    idle(2);

    // R7 terminal count set conditions
    irq_enable = 1'b1;
    for (int sel = 0; sel < 4; sel++)
      for (int d = 0; d < 5; d++)
        for (int en = 0; en < 2; en++) begin
          bit exp_set;
          do_write(10'(BASE + 5), 8'h00);
          tc_irq_mode = en[0]; dma_ch_sel = 2'(sel);
          @(negedge clk);
          dma_tc = 1'b1; dma_ack = (d < 4) ? 4'(1 << d) : 4'b0;
          @(negedge clk);
          dma_tc = 1'b0; dma_ack = '0;
          exp_set = en[0] && (d == sel);
          @(negedge clk);
          check("R7 irq from flag", irq, exp_set);
          do_read(10'(BASE + 4));
          check("R7 status tc bit", snap_rd, status_exp(1, 0, exp_set, 0));
        end

    // R7 hold while acknowledge alone toggles, then R8 clear with varied data
    tc_irq_mode = 1'b1; dma_ch_sel = 2'd2;
    for (int i = 0; i < 3; i++) begin
      logic [7:0] dv;
      dv = (i == 0) ? 8'h00 : (i == 1) ? 8'hFF : 8'hA5;
      @(negedge clk); dma_tc = 1'b1; dma_ack = 4'b0100;
      @(negedge clk); dma_tc = 1'b0; dma_ack = 4'b0100;
      idle(3); dma_ack = '0;
      do_read(10'(BASE + 4));
      check("R7 flag holds", snap_rd[5], 0);
      do_write(10'(BASE + 5), dv);
      do_read(10'(BASE + 4));
      check("R8 clear any data", snap_rd[5], 1);
      check("R10 irq drops after clear", irq, 0);
    end

    // R8 set and clear in the same cycle
    @(negedge clk);
    io_addr = 10'(BASE + 5); io_wr = 1'b1; dma_tc = 1'b1; dma_ack = 4'b0100;
    @(negedge clk);
    io_wr = 1'b0; dma_tc = 1'b0; dma_ack = '0;
    do_read(10'(BASE + 4));
    check("R8 set wins over clear", snap_rd[5], 0);
    do_write(10'(BASE + 5), 8'h3C);
    do_read(10'(BASE + 4));
    check("R8 later clear", snap_rd[5], 1);

    // R10 controller interrupt merge and gating
    scc_irq = 1'b1; irq_enable = 1'b0;
    idle(2);
    check("R10 gated off", irq, 0);
    irq_enable = 1'b1;
    idle(2);
    check("R10 controller interrupt", irq, 1);
    do_write(10'(BASE + 5), 8'hFF);
    do_write(10'(BASE + 4), 8'hFF);
    idle(1);
    check("R10 writes do not clear controller irq", irq, 1);
    do_read(10'(BASE + 4));
    check("R10 status still pending", snap_rd[3], 0);
    scc_irq = 1'b0;
    idle(2);
    check("R10 irq follows controller", irq, 0);

    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule